// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Pin Read-Back Select

This block is one general-purpose I/O port with a parameterised number of pins (eight by default). The processor reaches it through a small register bus. The port holds two registers. The output latch sets the level driven on each pin that is configured as an output. The direction register decides, for each pin, whether the pin drives or listens. A pin that is configured as an output always drives push-pull; there is no open-drain mode.

A read of the latch address is assembled bit by bit:

- An input pin returns its pad level. That level is taken through a two-flop synchronizer at the moment of the read and is not stored.
- An output pin returns its latch bit.

Because of this, a read-modify-write sequence in software never corrupts the values that output pins are driving.

Besides whole-byte writes, the bus accepts a single-bit set command and a single-bit clear command. These change one selected bit of the addressed register and leave every other bit untouched.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction bit is 1, so every pin is an input and `pad_oe` is all zero. The output latch resets to all zero.
- R2: `pad_oe[i]` is high exactly when direction bit i is 0. `pad_out` always equals the output latch.
- R3: A write with `bit_op`=2'b00 at `BASE_ADDR` (an even address) loads `wr_data` into the output latch. The latch then holds that value until it is written again.
- R4: A write with `bit_op`=2'b00 at `BASE_ADDR`+1 loads `wr_data` into the direction register. A read of that address returns the direction register.
- R5: A read of `BASE_ADDR` returns the synchronized pad level in bit i when direction bit i is 1. It returns latch bit i when direction bit i is 0.
- R6: A write with `bit_op`=2'b01 sets bit `bit_idx` of the addressed register and leaves its other bits unchanged.
- R7: A write with `bit_op`=2'b10 clears bit `bit_idx` of the addressed register and leaves its other bits unchanged.
- R8: A write with `bit_op`=2'b11 changes neither register.
- R9: A write to any address other than `BASE_ADDR` and `BASE_ADDR`+1 has no effect. A read of such an address returns 0.
- R10: A change on `pad_in` first appears in read data after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| bit_op | input | 2 | 00 byte write, 01 bit set, 10 bit clear, 11 no-op |
| bit_idx | input | clog2(WIDTH) | Bit selected by set/clear |
| wr_data | input | WIDTH | Byte write data |
| rd_data | output | WIDTH | Combinational read data |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output levels |
| pad_oe | output | WIDTH | Per-pin output enable |

## Verification
Random mixtures of direction masks, pad levels and latch contents are used on every read of the latch address. Each bit should come from the pad or from the latch according to its direction bit, so any swap of the two sources is exposed. Set and clear commands are aimed at random bit positions, including bits 0 and 7. This tells apart a correct single-bit update from one that disturbs neighbouring bits or picks the wrong index. Directed sequences cover three further cases:

- An input pin's pad level is read after one clock edge and after two, which pins down the synchronizer depth.
- Writes using the reserved command leave both registers unchanged.
- Writes to unmapped addresses leave both registers unchanged, and reads of those addresses return 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_NONE = 2'b11
  } bitop_e;

  // Next value of a register given a bus command.
  function automatic logic [7:0] next_reg(input logic [7:0] cur, input logic [7:0] wdata,
                                          input bitop_e op, input int idx);
    logic [7:0] r;
    r = cur;
    case (op)
      OP_BYTE: r = wdata;
      OP_SET:  r[idx] = 1'b1;
      OP_CLR:  r[idx] = 1'b0;
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_sync
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      stage1[i] <= pad_in[i];
      stage2[i] <= stage1[i];
    end
  end

  assign pad_sync = stage2;

  // R10: read path sees the pad level from two edges back
  a_r10_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    pad_sync == $past(pad_in, 2));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             ctrl_we,
  input  bitop_e           op,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] dir_d;

  function automatic logic [WIDTH-1:0] apply(input logic [WIDTH-1:0] cur);
    logic [WIDTH-1:0] r;
    r = cur;
    case (op)
      OP_BYTE: r = wdata;
      OP_SET:  r[idx] = 1'b1;
      OP_CLR:  r[idx] = 1'b0;
      default: r = cur;
    endcase
    return r;
  endfunction

  always_comb begin
    latch_d = data_we ? apply(latch_q) : latch_q;
    dir_d   = ctrl_we ? apply(dir_q) : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  a_r1_reset_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && latch_q == '0));
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(latch_q));
  a_r4_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(dir_q));
  a_r6_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && op == OP_SET) |=> latch_q[$past(idx)]);
  a_r7_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && op == OP_CLR) |=> !latch_q[$past(idx)]);
  a_r8_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> ($stable(latch_q) && $stable(dir_q)));
  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && (op == OP_SET || op == OP_CLR)) |=>
      $countones(latch_q ^ $past(latch_q)) <= 1);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h12,
  localparam int IDX_W = $clog2(WIDTH),
  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR | 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        bit_op,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  logic             hit_data;
  logic             hit_ctrl;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pad_sync;
  logic [WIDTH-1:0] data_view;

  assign hit_data = (addr == BASE_ADDR);
  assign hit_ctrl = (addr == CTRL_ADDR);

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_sync(pad_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .data_we(wr_en && hit_data), .ctrl_we(wr_en && hit_ctrl),
    .op(bitop_e'(bit_op)), .idx(bit_idx), .wdata(wr_data),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_rd
    assign data_view[i] = dir_q[i] ? pad_sync[i] : latch_q[i];
  end

  always_comb begin
    if (hit_data)      rd_data = data_view;
    else if (hit_ctrl) rd_data = dir_q;
    else               rd_data = '0;
  end

  assign pad_out = latch_q;
  assign pad_oe  = ~dir_q;

  // R9: stray writes leave port outputs alone
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_data && !hit_ctrl) |=> ($stable(pad_out) && $stable(pad_oe)));
  // R5: output pins read back what they drive
  a_r5_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |-> ((rd_data & pad_oe) == (pad_out & pad_oe)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam logic [7:0] BASE = 8'h12;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0;
  logic       wr_en = 0;
  logic [1:0] bit_op = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] m_latch, m_dir, m_pad;

  always #5 clk = ~clk;

  gpio_port u_dut (.*);

  function automatic logic [7:0] upd(input logic [7:0] cur, input logic [7:0] d,
                                     input logic [1:0] op, input int i);
    logic [7:0] r = cur;
    if (op == 2'd0) r = d;
    else if (op == 2'd1) r = cur | (8'd1 << i);
    else if (op == 2'd2) r = cur & ~(8'd1 << i);
    return r;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == BASE) return (m_dir & m_pad) | (~m_dir & m_latch);
    if (a == (BASE | 8'd1)) return m_dir;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [1:0] op, input int i, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1; bit_op = op; bit_idx = 3'(i); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == BASE) m_latch = upd(m_latch, d, op, i);
    else if (a == (BASE | 8'd1)) m_dir = upd(m_dir, d, op, i);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    addr = a; #1;
    chk(req, rd_data, exp_read(a));
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk); pad_in = v; m_pad = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    rd_chk({tag, " R5 data read"}, BASE);
    rd_chk({tag, " R4 ctrl read"}, BASE | 8'd1);
    chk({tag, " R2 pad_out"}, pad_out, m_latch);
    chk({tag, " R2 pad_oe"}, pad_oe, ~m_dir);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_latch = 8'h00; m_dir = 8'hFF; m_pad = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 latch", pad_out, 8'h00);
    rd_chk("R1 dir", BASE | 8'd1);

    // R10 synchronizer depth
    @(negedge clk); pad_in = 8'hA5;
    @(negedge clk); addr = BASE; #1;
    chk("R10 after one edge", rd_data, 8'h00);
    @(negedge clk); #1;
    chk("R10 after two edges", rd_data, 8'hA5);
    m_pad = 8'hA5;

    // R3 byte write and hold
    bus_wr(BASE, 2'd0, 0, 8'h3C);
    bus_wr(BASE | 8'd1, 2'd0, 0, 8'h00);
    check_all("R3 byte");
    repeat (4) @(negedge clk);
    chk("R3 hold", pad_out, 8'h3C);

    // R6/R7 edge bits
    bus_wr(BASE, 2'd1, 7, 8'h00); chk("R6 set bit7", pad_out, m_latch);
    bus_wr(BASE, 2'd2, 2, 8'hFF); chk("R7 clear bit2", pad_out, m_latch);
    bus_wr(BASE, 2'd1, 0, 8'h00); chk("R6 set bit0", pad_out, m_latch);

    // R8 reserved op
    bus_wr(BASE, 2'd3, 1, 8'hFF);
    bus_wr(BASE | 8'd1, 2'd3, 1, 8'hFF);
    check_all("R8 no-op");

    // R9 stray address
    bus_wr(8'h40, 2'd0, 0, 8'hFF);
    bus_wr(BASE + 8'd2, 2'd0, 0, 8'hFF);
    check_all("R9 stray");
    rd_chk("R9 stray read", 8'h40);

    // Mixed random
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 3) set_pad(8'($urandom));
      else if (k < 6) bus_wr(BASE, 2'($urandom), $urandom_range(0, 7), 8'($urandom));
      else if (k < 8) bus_wr(BASE | 8'd1, 2'($urandom), $urandom_range(0, 7), 8'($urandom));
      else bus_wr(8'($urandom), 2'($urandom), $urandom_range(0, 7), 8'($urandom));
      check_all("rand R6 R7");
      rd_chk("rand R9", 8'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule